// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Pair

This block holds two identical down-counting timers, numbered 0 and 1, each with an 11-bit count. A timer advances on every cycle in which its run flag is set and its selected trigger is high. The trigger can be the system clock itself, one of two external single-cycle strobes, or the other timer's wrap pulse. When a timer is at zero and a trigger arrives, it wraps. In repeat mode it then loads its reload value and keeps counting. In one-shot mode it stops at zero and its run flag is cleared. Every wrap raises a one-cycle interrupt output.

Because each timer can be driven by its sibling's wrap, the pair can be chained into a single counter of twice the width. A typical setup has timer 0 running on the system clock and timer 1 counting the wraps of timer 0. Software uses a plain register port. A write takes effect at the next clock edge. A read is combinational from a separate read address. There is no stream interface, so there is no back-pressure.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, every register reads zero: run flag, mode, source, count and reload. Both interrupt outputs are low.
- R2: A running timer decrements by one in each cycle where its selected trigger is high. The trigger select is control bits 15:14: 0 means every cycle, 1 means `stc_strobe`, 2 means `rtc_strobe`, 3 means the other timer's wrap. A strobe that is not selected has no effect.
- R3: A wrap happens in the cycle where the count is zero, the run flag is set and the trigger is high. The timer's `wrap_irq` bit goes high on the next clock edge and stays high for exactly one cycle.
- R4: In repeat mode (control bit 13 = 1), a wrap loads the reload value into the count.
- R5: In one-shot mode (control bit 13 = 0), a wrap leaves the count at zero and clears the run flag (control bit 11).
- R6: When the run flag is 0, the count holds its value whatever the trigger does.
- R7: Writing the reload register does not change the running count. The new value is used at the next wrap.
- R8: The count register can be written at any time, and counting continues from the written value. A count write wins over a decrement or reload in the same cycle.
- R9: When timer 1 selects source 3, it decrements once per wrap of timer 0, one cycle after that wrap. Timer 0 reloads in its own wrap cycle.
- R10: A software write to the control register in the same cycle as a one-shot hardware clear sets the run flag to the written value.
- R11: Register map: address bit 2 selects the timer, and address bits 1:0 select control (0), count (1) or reload (2). Control reads back bit 11 run, bit 13 repeat and bits 15:14 source, with all other bits zero. Count and reload read zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stc_strobe | input | 1 | External single-cycle trigger strobe, source 1 |
| rtc_strobe | input | 1 | External single-cycle trigger strobe, source 2 |
| reg_wr | input | 1 | Register write enable |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Read data, combinational from `reg_raddr` |
| wrap_irq | output | 2 | One-cycle wrap pulse per timer, bit i for timer i |

## Verification
The hardest case to reach is a software control write that lands in the exact edge where a one-shot timer at zero clears its own run flag. The bench loads a count of one and starts the timer. It then lets one cycle pass and writes the control register on the following edge, so both events meet. The cascade case needs the same cycle accounting. The bench counts edges from the start write to predict how many timer-0 wraps have reached timer 1 at the point it samples.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int GO_BIT  = 11;
  localparam int RPT_BIT = 13;
  localparam int SRC_LSB = 14;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_STC  = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_PEER = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    RSEL_CTRL   = 2'd0,
    RSEL_COUNT  = 2'd1,
    RSEL_RELOAD = 2'd2,
    RSEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ctp_src_mux.sv
module ctp_src_mux
  import ctp_pkg::*;
(
  input  trig_src_e src,
  input  logic      stc_strobe,
  input  logic      rtc_strobe,
  input  logic      peer_wrap,
  output logic      trig
);
  always_comb begin
    unique case (src)
      SRC_CLK:  trig = 1'b1;
      SRC_STC:  trig = stc_strobe;
      SRC_RTC:  trig = rtc_strobe;
      SRC_PEER: trig = peer_wrap;
      default:  trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctp_down_counter.sv
module ctp_down_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             rpt,
  input  logic [CNT_W-1:0] reload,
  input  logic             load_sw,
  input  logic [CNT_W-1:0] sw_val,
  output logic [CNT_W-1:0] count_q,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_d;

  assign at_zero = (count_q == '0);

  always_comb begin
    count_d = count_q;
    if (load_sw)
      count_d = sw_val;
    else if (advance) begin
      if (at_zero)
        count_d = rpt ? reload : '0;
      else
        count_d = count_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R2: one trigger, one step down
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_zero && !load_sw) |=> (count_q == $past(count_q) - ONE));
  // R4: repeat wrap loads reload value
  a_r4_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && at_zero && rpt && !load_sw) |=> (count_q == $past(reload)));
  // R6: no advance, no change
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load_sw) |=> $stable(count_q));
  // R8: software load wins
  a_r8_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_sw |=> (count_q == $past(sw_val)));
endmodule

// File: rtl/ctp_channel.sv
module ctp_channel
  import ctp_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stc_strobe,
  input  logic             rtc_strobe,
  input  logic             peer_wrap,
  input  logic             ctrl_we,
  input  logic             count_we,
  input  logic             reload_we,
  input  logic             wr_go,
  input  logic             wr_rpt,
  input  logic [1:0]       wr_src,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             go_q,
  output logic             rpt_q,
  output logic [1:0]       src_q,
  output logic             wrap_q
);
  logic trig;
  logic tick;
  logic at_zero;
  logic wrap_d;
  logic go_d;

  ctp_src_mux u_mux (
    .src        (trig_src_e'(src_q)),
    .stc_strobe (stc_strobe),
    .rtc_strobe (rtc_strobe),
    .peer_wrap  (peer_wrap),
    .trig       (trig)
  );

  assign tick   = go_q & trig;
  assign wrap_d = tick & at_zero;

  ctp_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (tick),
    .rpt     (rpt_q),
    .reload  (reload_q),
    .load_sw (count_we),
    .sw_val  (wr_val),
    .count_q (count_q),
    .at_zero (at_zero)
  );

  // Software write to the control register takes priority over hardware clear
  always_comb begin
    go_d = go_q;
    if (ctrl_we)
      go_d = wr_go;
    else if (wrap_d && !rpt_q)
      go_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      rpt_q    <= 1'b0;
      src_q    <= 2'd0;
      reload_q <= '0;
      wrap_q   <= 1'b0;
    end else begin
      go_q   <= go_d;
      wrap_q <= wrap_d;
      if (ctrl_we) begin
        rpt_q <= wr_rpt;
        src_q <= wr_src;
      end
      if (reload_we)
        reload_q <= wr_val;
    end
  end

  // R3: a pulse only follows a terminal trigger
  a_r3_wrap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> $past(tick && at_zero));
  // R5: one-shot terminal trigger stops the timer
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !rpt_q && !ctrl_we) |=> !go_q);
  // R10: written run flag wins
  a_r10_sw_go_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (go_q == $past(wr_go)));
  // R6: paused timer never wraps
  a_r6_no_wrap_paused: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |=> !wrap_q);
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctp_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stc_strobe,
  input  logic              rtc_strobe,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [1:0]        wrap_irq
);
  localparam int NUM_TMR = 2;

  logic [CNT_W-1:0] cnt_a [NUM_TMR];
  logic [CNT_W-1:0] rld_a [NUM_TMR];
  logic [1:0]       src_a [NUM_TMR];
  logic             go_a  [NUM_TMR];
  logic             rpt_a [NUM_TMR];
  logic [NUM_TMR-1:0] wrap_v;
  logic             wdata_unused;

  reg_sel_e wsel;
  reg_sel_e rsel;

  assign wsel         = reg_sel_e'(reg_waddr[1:0]);
  assign rsel         = reg_sel_e'(reg_raddr[1:0]);
  assign wdata_unused = ^reg_wdata;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic hit;
    assign hit = reg_wr && (reg_waddr[2] == 1'(i));

    ctp_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .stc_strobe (stc_strobe),
      .rtc_strobe (rtc_strobe),
      .peer_wrap  (wrap_v[NUM_TMR-1-i]),
      .ctrl_we    (hit && wsel == RSEL_CTRL),
      .count_we   (hit && wsel == RSEL_COUNT),
      .reload_we  (hit && wsel == RSEL_RELOAD),
      .wr_go      (reg_wdata[GO_BIT]),
      .wr_rpt     (reg_wdata[RPT_BIT]),
      .wr_src     (reg_wdata[SRC_LSB +: 2]),
      .wr_val     (reg_wdata[CNT_W-1:0]),
      .count_q    (cnt_a[i]),
      .reload_q   (rld_a[i]),
      .go_q       (go_a[i]),
      .rpt_q      (rpt_a[i]),
      .src_q      (src_a[i]),
      .wrap_q     (wrap_v[i])
    );
  end

  assign wrap_irq = wrap_v;

  always_comb begin
    reg_rdata = '0;
    unique case (rsel)
      RSEL_CTRL: begin
        reg_rdata[GO_BIT]        = go_a[reg_raddr[2]];
        reg_rdata[RPT_BIT]       = rpt_a[reg_raddr[2]];
        reg_rdata[SRC_LSB +: 2]  = src_a[reg_raddr[2]];
      end
      RSEL_COUNT:  reg_rdata[CNT_W-1:0] = cnt_a[reg_raddr[2]];
      RSEL_RELOAD: reg_rdata[CNT_W-1:0] = rld_a[reg_raddr[2]];
      default:     reg_rdata = '0;
    endcase
  end

  // R9: cascaded timer 1 steps only one cycle after a timer-0 wrap
  a_r9_cascade_step: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a[1] == 2'd3 && go_a[1] && !wrap_v[0] &&
     !(reg_wr && reg_waddr[2])) |=> $stable(cnt_a[1]));
endmodule

// File: tb/cascade_timer_pair_tb.sv
`timescale 1ns/10ps
module cascade_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stc_strobe = 1'b0;
  logic        rtc_strobe = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  wrap_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_timer_pair u_dut (
    .clk(clk), .rst_n(rst_n), .stc_strobe(stc_strobe), .rtc_strobe(rtc_strobe),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .wrap_irq(wrap_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [7:0]  waitn;
    logic [2:0]  raddr;
    logic [15:0] expv;
    logic [3:0]  req;
  } step_t;

  // addr: 0 ctrl0, 1 count0, 2 reload0, 4 ctrl1, 5 count1, 6 reload1
  localparam step_t TABLE [13] = '{
    '{1'b1, 3'd1, 16'd10,   8'd0, 3'd1, 16'd10,   4'd8},  // R8 idle load
    '{1'b1, 3'd2, 16'd5,    8'd0, 3'd1, 16'd10,   4'd7},  // R7 reload leaves count
    '{1'b1, 3'd0, 16'h2800, 8'd3, 3'd1, 16'd7,    4'd2},  // R2 every-cycle source
    '{1'b1, 3'd2, 16'd3,    8'd0, 3'd1, 16'd6,    4'd7},  // R7 reload while running
    '{1'b0, 3'd0, 16'd0,    8'd6, 3'd1, 16'd0,    4'd2},  // R2 down to zero
    '{1'b0, 3'd0, 16'd0,    8'd1, 3'd1, 16'd3,    4'd4},  // R4 new reload used
    '{1'b1, 3'd0, 16'h2000, 8'd5, 3'd1, 16'd2,    4'd6},  // R6 paused holds
    '{1'b1, 3'd0, 16'h2800, 8'd0, 3'd0, 16'h2800, 4'd11}, // R11 ctrl readback
    '{1'b1, 3'd1, 16'd100,  8'd2, 3'd1, 16'd98,   4'd8},  // R8 write beats step
    '{1'b1, 3'd0, 16'h0800, 8'd0, 3'd1, 16'd97,   4'd2},  // R2 step on ctrl edge
    '{1'b1, 3'd1, 16'd2,    8'd3, 3'd0, 16'h0000, 4'd5},  // R5 run flag cleared
    '{1'b0, 3'd0, 16'd0,    8'd0, 3'd1, 16'd0,    4'd5},  // R5 count stays zero
    '{1'b0, 3'd0, 16'd0,    8'd0, 3'd2, 16'd3,    4'd11}  // R11 reload readback
  };

  task automatic tick_wait(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input bit use_rtc);
    if (use_rtc) rtc_strobe = 1'b1; else stc_strobe = 1'b1;
    @(negedge clk); #1;
    rtc_strobe = 1'b0; stc_strobe = 1'b0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    reg_raddr = a;
    #0.1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hits;
    int first;
    tick_wait(4);
    rst_n = 1'b1;
    tick_wait(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      if (a % 4 != 3) rd_chk("R1", 3'(a), 16'h0000);
    end
    chk("R1", {14'd0, wrap_irq}, 16'h0000);

    for (int s = 0; s < 13; s++) begin
      if (TABLE[s].wr) wr(TABLE[s].addr, TABLE[s].data);
      tick_wait(int'(TABLE[s].waitn));
      rd_chk($sformatf("R%0d step %0d", TABLE[s].req, s), TABLE[s].raddr, TABLE[s].expv);
    end

    // R3 one-cycle registered pulse, three edges after start with count 2
    wr(3'd1, 16'd2);
    wr(3'd0, 16'h0800);
    hits = 0; first = 0;
    for (int k = 1; k <= 8; k++) begin
      tick_wait(1);
      if (wrap_irq[0]) begin hits++; if (first == 0) first = k; end
      chk("R3 timer1 quiet", {15'd0, wrap_irq[1]}, 16'd0);
    end
    chk("R3 pulse count", 16'(hits), 16'd1);
    chk("R3 pulse cycle", 16'(first), 16'd3);

    // R2 strobe sources on timer 1
    wr(3'd5, 16'd5);
    wr(3'd4, 16'h4800);
    for (int k = 0; k < 3; k++) begin pulse(1'b0); tick_wait(1); end
    rd_chk("R2 stc source", 3'd5, 16'd2);
    for (int k = 0; k < 2; k++) begin pulse(1'b1); tick_wait(1); end
    rd_chk("R2 rtc ignored", 3'd5, 16'd2);
    wr(3'd4, 16'h8800);
    pulse(1'b1);
    rd_chk("R2 rtc source", 3'd5, 16'd1);
    pulse(1'b0);
    rd_chk("R2 stc ignored", 3'd5, 16'd1);

    // R9 cascade: timer0 period 4 on clock, timer1 on timer0 wrap
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd3);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'd10);
    wr(3'd6, 16'd10);
    wr(3'd4, 16'hE800);
    wr(3'd0, 16'h2800);
    tick_wait(20);
    rd_chk("R9 upper count", 3'd5, 16'd6);
    rd_chk("R9 lower count", 3'd1, 16'd3);

    // R10 control write meets one-shot clear
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd1);
    wr(3'd0, 16'h0800);
    tick_wait(1);
    wr(3'd0, 16'h0800);
    rd_chk("R10 run flag kept", 3'd0, 16'h0800);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule